// File: doc/BRIEF.md
# Per-Pin Pull Resistor Controller

This block holds a 2-bit pull setting for each of 58 pads and drives a pull-up enable and a pull-down enable per pad. Software can program the settings in two ways, each through its own write port. The direct port writes packed per-pin fields, sixteen pins to a 32-bit word. The legacy port first loads one shared pull code. It then strobes that code into chosen pins by raising their bits in two per-bank clock registers.

The two models use different encodings. The block translates the legacy code into the direct encoding at the moment a pin latches it. A single combinational read port returns the direct words, the shared code and the clock registers. The pull state itself can be read back only through the direct words. Both write ports may act in the same cycle. When both touch one pin, the direct write decides that pin's setting.

Top module: `pull_ctl`

## Requirements
- R1: After reset every pin field is 0, both enables of every pin are low, and the shared code and both clock registers read 0.
- R2: A direct-port write to byte address 0xE4+4*w loads pins 16*w to 16*w+15 (w from 0 to 3). Pin p takes bits [2*(p mod 16)+1 : 2*(p mod 16)]. The new value is visible on the outputs and on a read of the same address from the cycle after the write.
- R3: A direct field value of 1 raises only pull_up_en, a value of 2 raises only pull_dn_en, and values 0 and 3 raise neither.
- R4: A legacy-port write to 0x94 stores wdata[1:0] as the shared code. A read of 0x94 returns the code in bits [1:0], with all other bits zero.
- R5: Clock registers sit at 0x98 (pins 0 to 31, bit p) and 0x9C (pins 32 to 57, bit p-32). Setting a bit from 0 to 1 latches the translated shared code into that pin. The translation is code 0 to 0, code 1 to 2 (pull-down), code 2 to 1 (pull-up) and code 3 to 0.
- R6: A pin keeps its setting in three cases: its clock bit is written 1 while already 1, its clock bit is cleared, or only the shared code changes.
- R7: In a cycle where a direct write covers a pin whose clock bit rises, the pin takes the direct field value. Pins outside that direct word still latch the legacy code.
- R8: Fields and clock bits for pin indices of 58 and above are ignored on write and read as zero.
- R9: Each write port decodes only its own addresses. A write to any other address, or to the other port's registers, changes nothing. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dw_en | input | 1 | Direct-port write strobe |
| dw_addr | input | 8 | Direct-port byte address |
| dw_data | input | 32 | Direct-port write data |
| lw_en | input | 1 | Legacy-port write strobe |
| lw_addr | input | 8 | Legacy-port byte address |
| lw_data | input | 32 | Legacy-port write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data, combinational on rd_addr |
| pull_up_en | output | 58 | Per-pin pull-up enable |
| pull_dn_en | output | 58 | Per-pin pull-down enable |

## Verification
A direct word write and a legacy clock-bit rise can fall in the same cycle, because each arrives on its own port. The bench drives both strobes on the same clock edge. The legacy write raises the clock bits of one pin inside the direct word and one pin outside it. The bench then expects the pin inside the word to carry the direct field and the pin outside it to carry the translated legacy code, judged on both the enables and the direct readback.

// File: rtl/pull_ctl.sv
module pull_ctl #(
  parameter int NPINS = 58,
  parameter int AW = 8,
  parameter logic [AW-1:0] CODE_ADDR = 'h94,
  parameter logic [AW-1:0] CLK_BASE  = 'h98,
  parameter logic [AW-1:0] DIR_BASE  = 'hE4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dw_en,
  input  logic [AW-1:0]    dw_addr,
  input  logic [31:0]      dw_data,
  input  logic             lw_en,
  input  logic [AW-1:0]    lw_addr,
  input  logic [31:0]      lw_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [31:0]      rd_data,
  output logic [NPINS-1:0] pull_up_en,
  output logic [NPINS-1:0] pull_dn_en
);

  localparam int NWORDS = (NPINS + 15) / 16;
  localparam int LAST_FIELDS = NPINS - 16 * (NWORDS - 1);
  localparam logic [AW-1:0] LAST_WORD = DIR_BASE + AW'(4 * (NWORDS - 1));

  logic [1:0]       pull_q [NPINS];
  logic [1:0]       code_q;
  logic [NPINS-1:0] clk_q, clk_d, rise, dir_hit;

  function automatic logic [1:0] xlate(input logic [1:0] c);
    case (c)
      2'd1:    return 2'd2;
      2'd2:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  always_comb begin
    clk_d = clk_q;
    for (int p = 0; p < NPINS; p++) begin
      if (lw_en && lw_addr == CLK_BASE + AW'(4 * (p / 32)))
        clk_d[p] = lw_data[p % 32];
      dir_hit[p] = dw_en && (dw_addr == DIR_BASE + AW'(4 * (p / 16)));
    end
    rise = clk_d & ~clk_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      clk_q  <= '0;
      for (int p = 0; p < NPINS; p++) pull_q[p] <= '0;
    end else begin
      if (lw_en && lw_addr == CODE_ADDR) code_q <= lw_data[1:0];
      clk_q <= clk_d;
      for (int p = 0; p < NPINS; p++) begin
        if (dir_hit[p])   pull_q[p] <= dw_data[2*(p%16) +: 2];
        else if (rise[p]) pull_q[p] <= xlate(code_q);
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == CODE_ADDR) rd_data[1:0] = code_q;
    for (int p = 0; p < NPINS; p++) begin
      if (rd_addr == CLK_BASE + AW'(4 * (p / 32)))
        rd_data[p % 32] = clk_q[p];
      if (rd_addr == DIR_BASE + AW'(4 * (p / 16)))
        rd_data[2*(p%16) +: 2] = pull_q[p];
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pad
    assign pull_up_en[p] = (pull_q[p] == 2'd1);
    assign pull_dn_en[p] = (pull_q[p] == 2'd2);
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (pull_up_en == '0 && pull_dn_en == '0 && code_q == 2'd0 && clk_q == '0));

  assert_latch_R5: assert property (@(posedge clk) disable iff (rst)
    (lw_en && lw_addr == CLK_BASE && lw_data[0] && !clk_q[0] && !dir_hit[0])
    |=> pull_q[0] == xlate($past(code_q)));

  assert_held_bit_R6: assert property (@(posedge clk) disable iff (rst)
    (lw_en && lw_addr == CLK_BASE && lw_data[0] && clk_q[0] && !dir_hit[0])
    |=> $stable(pull_q[0]));

  assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (!dw_en && !lw_en) |=> ($stable(pull_up_en) && $stable(pull_dn_en)));

  assert_direct_wins_R7: assert property (@(posedge clk) disable iff (rst)
    dir_hit[0] |=> pull_q[0] == $past(dw_data[1:0]));

  assert_ghost_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == LAST_WORD) |-> ((rd_data >> (2 * LAST_FIELDS)) == 32'd0));

endmodule

// File: tb/pull_ctl_tb.sv
module pull_ctl_tb_top;
  logic        clk = 0, rst = 1;
  logic        dw_en = 0, lw_en = 0;
  logic [7:0]  dw_addr = 0, lw_addr = 0, rd_addr = 0;
  logic [31:0] dw_data = 0, lw_data = 0;
  logic [31:0] rd_data;
  logic [57:0] pull_up_en, pull_dn_en;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pull_ctl dut_i (.clk, .rst, .dw_en, .dw_addr, .dw_data, .lw_en, .lw_addr,
                  .lw_data, .rd_addr, .rd_data, .pull_up_en, .pull_dn_en);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit de, input logic [7:0] da, input logic [31:0] dd,
                     input bit le, input logic [7:0] la, input logic [31:0] ld);
    @(negedge clk);
    dw_en = de; dw_addr = da; dw_data = dd;
    lw_en = le; lw_addr = la; lw_data = ld;
    @(negedge clk);
    dw_en = 0; lw_en = 0;
  endtask

  task automatic dwr(input logic [7:0] a, input logic [31:0] d);
    cyc(1, a, d, 0, 0, 0);
  endtask

  task automatic lwr(input logic [7:0] a, input logic [31:0] d);
    cyc(0, 0, 0, 1, a, d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic pin(input string req, input int p, input bit up, input bit dn);
    chk(req, {30'd0, pull_up_en[p], pull_dn_en[p]}, {30'd0, up, dn});
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 up", {6'd0, pull_up_en[57:32]} | pull_up_en[31:0], 0);
    chk("R1 dn", {6'd0, pull_dn_en[57:32]} | pull_dn_en[31:0], 0);
    for (int w = 0; w < 4; w++) begin
      rd(8'hE4 + 8'(4*w), v); chk("R1 word", v, 0);
    end
    rd(8'h94, v); chk("R1 code", v, 0);
    rd(8'h98, v); chk("R1 clk0", v, 0);
    rd(8'h9C, v); chk("R1 clk1", v, 0);
  endtask

  task automatic t_direct;
    logic [31:0] v;
    dwr(8'hE4, 32'h0000_0039);
    pin("R3 pin0 up", 0, 1, 0);
    pin("R3 pin1 dn", 1, 0, 1);
    pin("R3 pin2 code3", 2, 0, 0);
    rd(8'hE4, v); chk("R2 word0", v, 32'h39);
    dwr(8'hEC, 32'h8000_0001);
    pin("R2 pin32 up", 32, 1, 0);
    pin("R2 pin47 dn", 47, 0, 1);
    rd(8'hEC, v); chk("R2 word2", v, 32'h8000_0001);
  endtask

  task automatic t_legacy;
    logic [31:0] v;
    lwr(8'h94, 32'hFFFF_FFF1);
    rd(8'h94, v); chk("R4 code", v, 32'h1);
    lwr(8'h98, 32'h20);
    pin("R5 pin5 code1 dn", 5, 0, 1);
    lwr(8'h9C, 32'h8);
    pin("R5 pin35 bank1", 35, 0, 1);
    lwr(8'h94, 32'h2);
    lwr(8'h98, 32'h60);
    pin("R6 pin5 held", 5, 0, 1);
    pin("R5 pin6 code2 up", 6, 1, 0);
    lwr(8'h94, 32'h3);
    lwr(8'h98, 32'h20);
    pin("R6 pin6 cleared", 6, 1, 0);
    lwr(8'h98, 32'h60);
    pin("R5 pin6 code3 none", 6, 0, 0);
    rd(8'hE4, v); chk("R5 word0 readback", v, 32'h0000_0839 & ~32'h3000 | 32'h0000_0800);
  endtask

  task automatic t_code_only;
    lwr(8'h94, 32'h2);
    pin("R6 code only pin5", 5, 0, 1);
    pin("R6 code only pin6", 6, 0, 0);
  endtask

  task automatic t_conflict;
    logic [31:0] v;
    lwr(8'h98, 32'h0);
    cyc(1, 8'hE4, 32'h2 << 18, 1, 8'h98, 32'h0010_0200);
    pin("R7 pin9 direct wins", 9, 0, 1);
    pin("R7 pin20 legacy", 20, 1, 0);
    pin("R7 pin0 direct zero", 0, 0, 0);
    rd(8'hE4, v); chk("R7 word0", v, 32'h2 << 18);
    rd(8'hE8, v); chk("R7 word1", v, 32'h1 << 8);
  endtask

  task automatic t_ghost;
    logic [31:0] v;
    dwr(8'hF0, 32'hFFFF_FFFF);
    rd(8'hF0, v); chk("R8 word3", v, 32'h000F_FFFF);
    pin("R8 pin57 code3", 57, 0, 0);
    lwr(8'h9C, 32'hFFFF_FFFF);
    rd(8'h9C, v); chk("R8 clk1", v, 32'h03FF_FFFF);
    pin("R8 pin57 latched up", 57, 1, 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    dwr(8'h94, 32'h3);
    rd(8'h94, v); chk("R9 code via direct", v, 32'h2);
    lwr(8'hE4, 32'hFFFF_FFFF);
    rd(8'hE4, v); chk("R9 word via legacy", v, 32'h2 << 18);
    cyc(1, 8'hA0, 32'hFFFF_FFFF, 1, 8'hA0, 32'hFFFF_FFFF);
    rd(8'hA0, v); chk("R9 unmapped read", v, 0);
    pin("R9 pin9 untouched", 9, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset;
    t_direct;
    t_legacy;
    t_code_only;
    t_conflict;
    t_ghost;
    t_unmapped;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule